// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Parity Flag

This block receives asynchronous serial characters on a single line. A free-running tick at sixteen times the bit rate paces it. The line passes through a two-stage synchronizer. A falling edge starts a candidate frame, and the level near the middle of the start bit either confirms the frame or rejects it as noise. Data bits arrive least significant first and are sampled at the middle of each bit cell. A character is 7 or 8 bits long and may be followed by a parity bit. The receiver then checks a single stop bit.

When the stop bit has been sampled, the character moves from the shift register into a four-entry show-ahead FIFO. Parity is generated and compared with the received parity bit at that moment. One sticky flag reports that at least one stored character failed its check, without saying which one. Two more sticky flags report a low stop bit and a character lost because the FIFO was full. Each flag is cleared by pulsing its own clear input. The frame format is taken from a set of configuration inputs that are latched when a start edge is seen.

Top module: `uart_rx_core`

## Requirements
- R1: After synchronous reset the FIFO is empty (`rd_valid_o`=0, `full_o`=0) and `perr_o`, `ferr_o` and `ovr_o` are 0.
- R2: A frame is a low start bit, then data bits least significant first, then an optional parity bit, then one stop bit. `cfg_len8_i`=1 selects 8 data bits and 0 selects 7. Without parity, an 8-bit character appears on `rd_data_o` with `rd_bit8_o`=0. A 7-bit character appears on `rd_data_o[6:0]` with `rd_data_o[7]`=0 and `rd_bit8_o`=0.
- R3: In 7-bit mode with parity (`cfg_par_en_i`=1), the received parity bit is stored in `rd_data_o[7]`. It is compared with the parity generated over `rd_data_o[6:0]`.
- R4: In 8-bit mode with parity, the received parity bit is stored in `rd_bit8_o`. It is compared with the parity generated over `rd_data_o[7:0]`.
- R5: With `cfg_par_odd_i`=0 the expected parity bit is the XOR of the data bits; with 1 it is the inverse. A mismatch found when a character enters the FIFO sets `perr_o`, and the character is still stored.
- R6: `perr_o` stays set across later good characters until `clr_perr_i` is pulsed. A new error in the same cycle as the clear takes precedence.
- R7: The line must still be low at the eighth tick after the start edge is detected. If it is high there, the receiver returns to idle and stores nothing.
- R8: A low stop-bit sample sets `ferr_o` and the character is still stored. The receiver then waits for the line to go high before it looks for another start bit.
- R9: The FIFO holds 4 characters in arrival order, and `rd_en_i` with `rd_valid_o` pops the head. A character that completes while the FIFO is full is dropped and sets `ovr_o`. Its parity is not checked.
- R10: Only one stop bit is checked, so a start bit may follow directly after a single stop bit.
- R11: `ferr_o` and `ovr_o` stay set until `clr_ferr_i` and `clr_ovr_i` respectively are pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_len8_i | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_par_en_i | input | 1 | 1 = a parity bit follows the data |
| cfg_par_odd_i | input | 1 | 0 = even parity, 1 = odd parity |
| clr_perr_i | input | 1 | Pulse clears the parity-error flag |
| clr_ferr_i | input | 1 | Pulse clears the framing-error flag |
| clr_ovr_i | input | 1 | Pulse clears the overrun flag |
| rd_en_i | input | 1 | Pop the FIFO head |
| rd_data_o | output | 8 | FIFO head, data byte |
| rd_bit8_o | output | 1 | FIFO head, ninth received bit |
| rd_valid_o | output | 1 | FIFO not empty |
| full_o | output | 1 | FIFO holds 4 characters |
| perr_o | output | 1 | Sticky parity-error flag |
| ferr_o | output | 1 | Sticky framing-error flag |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The assertions check properties that hold on every cycle:
- the three flags stay set until their clears arrive;
- a flag rises only after a push that failed parity, or after a push that found the FIFO full;
- a rejected start returns the receiver to idle;
- a low line holds the receiver in its wait state;
- a stop sample always ends the frame after a single bit;
- a full FIFO neither grows nor pops when empty.

Only the bench scenarios can show that characters come out intact and in order for each format and parity sense, and that a short glitch leaves nothing behind. They also show that back-to-back frames with one stop bit are all received, and that a dropped character with bad parity leaves the parity flag clear.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
    } rx_cfg_t;

    typedef struct packed {
        logic       bit8;
        logic [7:0] data;
    } rx_char_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_STOP   = 3'd3,
        ST_WAITHI = 3'd4
    } rx_state_t;

    // number of bits between start and stop for a given format
    function automatic logic [3:0] frame_bits(rx_cfg_t c);
        logic [3:0] n;
        n = c.len8 ? 4'd8 : 4'd7;
        return n + {3'd0, c.par_en};
    endfunction

    // parity expected for the data part of a stored character
    function automatic logic gen_parity(rx_char_t ch, rx_cfg_t c);
        logic x;
        x = c.len8 ? ^ch.data : ^ch.data[6:0];
        return x ^ c.par_odd;
    endfunction

    // parity bit as it arrived on the line
    function automatic logic got_parity(rx_char_t ch, rx_cfg_t c);
        return c.len8 ? ch.bit8 : ch.data[7];
    endfunction

    function automatic logic parity_bad(rx_char_t ch, rx_cfg_t c);
        return c.par_en && (gen_parity(ch, c) != got_parity(ch, c));
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_i,
    input  logic     tick_i,
    input  rx_cfg_t  cfg_i,
    output logic     done_o,
    output logic     stop_bad_o,
    output rx_char_t char_o,
    output rx_cfg_t  cfg_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    rx_state_t              state_q;
    logic [CNT_W-1:0]       tcnt_q;
    logic [3:0]             bidx_q;
    logic [8:0]             sr_q;
    rx_cfg_t                cfg_q;
    logic [3:0]             last_idx;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= 1'b1;
                else     sync_q <= rx_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
            end
        end
    endgenerate

    assign rx_s     = sync_q[SYNC_STAGES-1];
    assign last_idx = frame_bits(cfg_q) - 4'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            tcnt_q     <= '0;
            bidx_q     <= '0;
            sr_q       <= '0;
            cfg_q      <= '0;
            done_o     <= 1'b0;
            stop_bad_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!rx_s) begin
                            state_q <= ST_START;
                            tcnt_q  <= '0;
                            cfg_q   <= cfg_i;
                        end
                    end
                    ST_START: begin
                        if (tcnt_q == MID_C) begin
                            if (rx_s) begin
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_DATA;
                                tcnt_q  <= '0;
                                bidx_q  <= '0;
                                sr_q    <= '0;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (tcnt_q == LAST_C) begin
                            tcnt_q <= '0;
                            for (int i = 0; i < 9; i++) begin
                                if (bidx_q == 4'(i)) sr_q[i] <= rx_s;
                            end
                            if (bidx_q == last_idx) state_q <= ST_STOP;
                            else                    bidx_q  <= bidx_q + 4'd1;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (tcnt_q == LAST_C) begin
                            done_o     <= 1'b1;
                            stop_bad_o <= !rx_s;
                            state_q    <= rx_s ? ST_IDLE : ST_WAITHI;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_WAITHI: begin
                        if (rx_s) state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign char_o = rx_char_t'(sr_q);
    assign cfg_o  = cfg_q;

    // R7: a high line at the mid-start sample abandons the frame
    a_r7_glitch_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && tick_i && tcnt_q == MID_C && rx_s) |=> state_q == ST_IDLE);

    // R8: while the line stays low after a bad stop, no new frame begins
    a_r8_wait_for_high: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAITHI && !rx_s) |=> state_q == ST_WAITHI);

    // R10: one stop sample always closes the frame
    a_r10_single_stop: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP && tick_i && tcnt_q == LAST_C) |=> (done_o && state_q != ST_STOP));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push_i,
    input  rx_char_t din_i,
    input  logic     pop_i,
    output rx_char_t head_o,
    output logic     empty_o,
    output logic     full_o,
    output logic     accepted_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    rx_char_t         mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full_o     = (cnt_q == CNT_FULL);
    assign empty_o    = (cnt_q == '0);
    assign do_push    = push_i && !full_o;
    assign do_pop     = pop_i && !empty_o;
    assign accepted_o = do_push;
    assign head_o     = mem_q[rptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wptr_q] <= din_i;
                wptr_q        <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
            end
            if (do_pop) begin
                rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R9: a push into a full FIFO without a pop leaves the occupancy alone
    a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full_o && push_i && !pop_i) |=> (full_o && $stable(wptr_q)));

    // R9: popping an empty FIFO moves nothing
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rptr_q)));

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     push_req_i,
    input  logic     push_ok_i,
    input  logic     stop_bad_i,
    input  rx_char_t char_i,
    input  rx_cfg_t  cfg_i,
    input  logic     clr_perr_i,
    input  logic     clr_ferr_i,
    input  logic     clr_ovr_i,
    output logic     perr_o,
    output logic     ferr_o,
    output logic     ovr_o
);
    logic set_perr, set_ferr, set_ovr;

    // parity is judged only for a character that actually enters the FIFO
    assign set_perr = push_ok_i && parity_bad(char_i, cfg_i);
    assign set_ferr = push_req_i && stop_bad_i;
    assign set_ovr  = push_req_i && !push_ok_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            perr_o <= 1'b0;
            ferr_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            if (set_perr)        perr_o <= 1'b1;
            else if (clr_perr_i) perr_o <= 1'b0;
            if (set_ferr)        ferr_o <= 1'b1;
            else if (clr_ferr_i) ferr_o <= 1'b0;
            if (set_ovr)         ovr_o  <= 1'b1;
            else if (clr_ovr_i)  ovr_o  <= 1'b0;
        end
    end

    // R6: parity flag persists until cleared
    a_r6_perr_sticky: assert property (@(posedge clk) disable iff (rst)
        (perr_o && !clr_perr_i) |=> perr_o);

    // R5: parity flag rises only after an accepted character
    a_r5_perr_needs_push: assert property (@(posedge clk) disable iff (rst)
        $rose(perr_o) |-> $past(push_ok_i));

    // R11: framing and overrun flags persist until cleared
    a_r11_ferr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ferr_o && !clr_ferr_i) |=> ferr_o);
    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_o && !clr_ovr_i) |=> ovr_o);

    // R9: overrun rises only when a finished character was refused
    a_r9_ovr_on_drop: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_o) |-> $past(push_req_i && !push_ok_i));

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    input  logic       tick16_i,
    input  logic       cfg_len8_i,
    input  logic       cfg_par_en_i,
    input  logic       cfg_par_odd_i,
    input  logic       clr_perr_i,
    input  logic       clr_ferr_i,
    input  logic       clr_ovr_i,
    input  logic       rd_en_i,
    output logic [7:0] rd_data_o,
    output logic       rd_bit8_o,
    output logic       rd_valid_o,
    output logic       full_o,
    output logic       perr_o,
    output logic       ferr_o,
    output logic       ovr_o
);
    rx_cfg_t  cfg_in, cfg_frame;
    rx_char_t ch, head;
    logic     done, stop_bad, push_ok, empty;

    assign cfg_in = '{len8: cfg_len8_i, par_en: cfg_par_en_i, par_odd: cfg_par_odd_i};

    uart_rx_frame #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .rx_i       (rx_i),
        .tick_i     (tick16_i),
        .cfg_i      (cfg_in),
        .done_o     (done),
        .stop_bad_o (stop_bad),
        .char_o     (ch),
        .cfg_o      (cfg_frame)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_i     (done),
        .din_i      (ch),
        .pop_i      (rd_en_i),
        .head_o     (head),
        .empty_o    (empty),
        .full_o     (full_o),
        .accepted_o (push_ok)
    );

    uart_rx_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .push_req_i (done),
        .push_ok_i  (push_ok),
        .stop_bad_i (stop_bad),
        .char_i     (ch),
        .cfg_i      (cfg_frame),
        .clr_perr_i (clr_perr_i),
        .clr_ferr_i (clr_ferr_i),
        .clr_ovr_i  (clr_ovr_i),
        .perr_o     (perr_o),
        .ferr_o     (ferr_o),
        .ovr_o      (ovr_o)
    );

    assign rd_data_o  = head.data;
    assign rd_bit8_o  = head.bit8;
    assign rd_valid_o = !empty;

endmodule

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
    localparam int BIT_CYC = 64;   // 16 ticks x 4 cycles per tick

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       len8 = 1'b1, pe = 1'b0, odd = 1'b0;
    logic       clr_perr = 1'b0, clr_ferr = 1'b0, clr_ovr = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit8, rd_valid, full, perr, ferr, ovr;

    int          n_chk = 0;
    int          n_fail = 0;
    logic        mon_en = 1'b0;
    logic [8:0]  exp_q [$];
    string       tag_q [$];

    uart_rx_core dut (
        .clk(clk), .rst(rst), .rx_i(rx), .tick16_i(tick),
        .cfg_len8_i(len8), .cfg_par_en_i(pe), .cfg_par_odd_i(odd),
        .clr_perr_i(clr_perr), .clr_ferr_i(clr_ferr), .clr_ovr_i(clr_ovr),
        .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_bit8_o(rd_bit8),
        .rd_valid_o(rd_valid), .full_o(full), .perr_o(perr),
        .ferr_o(ferr), .ovr_o(ovr)
    );

    initial forever #4 clk = ~clk;

    initial forever begin
        repeat (3) @(negedge clk) tick = 1'b0;
        @(negedge clk) tick = 1'b1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        @(negedge clk) rx = v;
        repeat (BIT_CYC - 1) @(negedge clk);
    endtask

    // driver: predicts the stored word, queues it, then serializes the frame
    task automatic send_char(input logic [7:0] d, input logic bad, input logic stopv,
                             input logic store, input string tag);
        logic       p;
        logic [8:0] e;
        int         nd;
        nd = len8 ? 8 : 7;
        p  = (len8 ? ^d : ^d[6:0]) ^ odd ^ bad;
        e  = len8 ? {(pe ? p : 1'b0), d} : {1'b0, (pe ? p : 1'b0), d[6:0]};
        if (store) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        drive_bit(1'b0);
        for (int i = 0; i < nd; i++) drive_bit(d[i]);
        if (pe) drive_bit(p);
        drive_bit(stopv);
    endtask

    task automatic idle(input int n);
        @(negedge clk) rx = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops every character the design offers and compares it
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en) begin
                rd_en = 1'b0;
            end else if (mon_en && rd_valid) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R9 unexpected character actual=%0h expected=none",
                             {rd_bit8, rd_data});
                end else begin
                    check(tag_q.pop_front(), int'({rd_bit8, rd_data}), int'(exp_q.pop_front()));
                end
                rd_en = 1'b1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rd_valid after reset", int'(rd_valid), 0);
        check("R1 full after reset", int'(full), 0);
        check("R1 flags after reset", int'({perr, ferr, ovr}), 0);
        mon_en = 1'b1;
        idle(40);

        // R2: plain 8-bit and 7-bit characters
        len8 = 1'b1; pe = 1'b0;
        send_char(8'hA5, 1'b0, 1'b1, 1'b1, "R2 8-bit no parity");
        send_char(8'h3C, 1'b0, 1'b1, 1'b1, "R2 8-bit no parity second");
        len8 = 1'b0;
        send_char(8'hFF, 1'b0, 1'b1, 1'b1, "R2 7-bit top bit zero");
        idle(40);

        // R3: 7-bit with even and odd parity
        pe = 1'b1; odd = 1'b0;
        send_char(8'h53, 1'b0, 1'b1, 1'b1, "R3 7-bit even parity in bit7");
        odd = 1'b1;
        send_char(8'h41, 1'b0, 1'b1, 1'b1, "R3 7-bit odd parity in bit7");
        idle(40);
        check("R3 no parity error on good 7-bit", int'(perr), 0);

        // R4: 8-bit with parity in the ninth bit
        len8 = 1'b1; odd = 1'b1;
        send_char(8'hC3, 1'b0, 1'b1, 1'b1, "R4 8-bit odd parity in bit8");
        odd = 1'b0;
        send_char(8'h81, 1'b0, 1'b1, 1'b1, "R4 8-bit even parity in bit8");
        idle(40);
        check("R4 no parity error on good 8-bit", int'(perr), 0);

        // R5: wrong parity sets the flag and the character is kept
        send_char(8'h5A, 1'b1, 1'b1, 1'b1, "R5 bad-parity char still stored");
        idle(40);
        check("R5 parity error flag set", int'(perr), 1);

        // R6: sticky across a good character, cleared by pulse
        send_char(8'h12, 1'b0, 1'b1, 1'b1, "R6 good char after error");
        idle(40);
        check("R6 perr still set", int'(perr), 1);
        @(negedge clk) clr_perr = 1'b1;
        @(negedge clk) clr_perr = 1'b0;
        @(negedge clk);
        check("R6 perr cleared", int'(perr), 0);

        // R7: short low glitch produces nothing
        @(negedge clk) rx = 1'b0;
        repeat (12) @(negedge clk);
        idle(300);
        check("R7 no character from glitch", int'(rd_valid), 0);
        check("R7 queue untouched by glitch", exp_q.size(), 0);
        send_char(8'h6E, 1'b0, 1'b1, 1'b1, "R7 normal char after glitch");
        idle(40);

        // R8: low stop bit, line held low, then released
        send_char(8'h99, 1'b0, 1'b0, 1'b1, "R8 char with bad stop stored");
        repeat (3 * BIT_CYC) @(negedge clk);
        check("R8 framing flag set", int'(ferr), 1);
        idle(BIT_CYC);
        send_char(8'h27, 1'b0, 1'b1, 1'b1, "R8 char after line recovers");
        idle(40);
        check("R8 no parity error from framing", int'(perr), 0);

        // R10: back-to-back frames with a single stop bit
        pe = 1'b0;
        send_char(8'h01, 1'b0, 1'b1, 1'b1, "R10 back-to-back first");
        send_char(8'h80, 1'b0, 1'b1, 1'b1, "R10 back-to-back second");
        send_char(8'h7F, 1'b0, 1'b1, 1'b1, "R10 back-to-back third");
        idle(40);
        check("R10 all consumed", exp_q.size(), 0);

        // R9: fill the FIFO, then one more with bad parity is dropped
        @(negedge clk) mon_en = 1'b0;
        pe = 1'b1; odd = 1'b0;
        send_char(8'h10, 1'b0, 1'b1, 1'b1, "R9 order entry 0");
        send_char(8'h20, 1'b0, 1'b1, 1'b1, "R9 order entry 1");
        send_char(8'h30, 1'b0, 1'b1, 1'b1, "R9 order entry 2");
        send_char(8'h40, 1'b0, 1'b1, 1'b1, "R9 order entry 3");
        idle(40);
        check("R9 full after four", int'(full), 1);
        check("R9 no overrun yet", int'(ovr), 0);
        send_char(8'hEE, 1'b1, 1'b1, 1'b0, "R9 dropped");
        idle(40);
        check("R9 overrun set", int'(ovr), 1);
        check("R9 dropped char parity not checked", int'(perr), 0);
        mon_en = 1'b1;
        idle(60);
        check("R9 drained in order", exp_q.size(), 0);
        check("R9 empty after drain", int'(rd_valid), 0);

        // R11: flags persist then clear by pulse
        check("R11 ferr still set", int'(ferr), 1);
        @(negedge clk) clr_ferr = 1'b1;
        @(negedge clk) clr_ferr = 1'b0;
        @(negedge clk);
        check("R11 ferr cleared", int'(ferr), 0);
        check("R11 ovr untouched by other clear", int'(ovr), 1);
        @(negedge clk) clr_ovr = 1'b1;
        @(negedge clk) clr_ovr = 1'b0;
        @(negedge clk);
        check("R11 ovr cleared", int'(ovr), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule